// File: doc/BRIEF.md
# Shared Up-Counter Timer with Banked Per-CPU Comparators

This block keeps one 64-bit up-counter that every CPU in a small cluster observes, driven by a programmable clock divider. Next to that counter sit up to four comparator banks, one per CPU. Each bank holds its own 64-bit compare value, a 32-bit auto-increment step, three control bits and an event flag. Each bank drives its own level interrupt line towards that CPU's private interrupt input; the system maps that line to private interrupt ID 27.

Software reaches the block through a plain 32-bit register port. Every access carries a CPU index, and that index picks which bank the banked registers and banked control bits refer to. The enable bit and the divider field are common to all CPUs, so any CPU writing the control word changes them for everyone. A bank that has auto-increment on moves its compare value forward by its step on every match. This produces a periodic event without software involvement. The counter itself cannot be written.

Top module: `sct_timer`

## Requirements
- R1: Register words sit at byte offsets 0x00 (counter bits 31:0), 0x04 (counter bits 63:32), 0x08 (control), 0x0C (status, event flag in bit 0), 0x10 (compare bits 31:0), 0x14 (compare bits 63:32) and 0x18 (auto-increment step); address bits 1:0 are ignored.
- R2: Control bit 0 (run) and bits 15:8 (divider) are common to all CPUs; control bit 1 (compare enable), bit 2 (interrupt enable) and bit 3 (auto-increment enable) are held separately for each CPU, and a control write updates the common bits plus the writing CPU's own banked bits.
- R3: A control read returns the reading CPU's banked bits 3:1 together with the common bits 0 and 15:8; every other bit reads as zero.
- R4: While run is set, the counter steps by one every divider+1 clocks, the first step landing divider+1 clocks after the write that set run from clear; while run is clear the counter holds.
- R5: When the counter takes a value equal to a CPU's compare value while run and that CPU's compare enable are set, that CPU's event flag is set one clock later.
- R6: A CPU's interrupt output rises only on a 0-to-1 change of its event flag while its interrupt enable is set; it stays high until the flag is cleared and is never high while the flag is clear.
- R7: On a match with auto-increment enabled, the compare value becomes compare + step in the same clock that sets the flag.
- R8: Writing status with bit 0 = 1 clears the writing CPU's event flag and interrupt; writing bit 0 = 0 changes nothing.
- R9: Each compare half is written on its own, leaving the other half unchanged.
- R10: After reset, the counter, every compare, step, control and status register, and every interrupt output read zero.
- R11: A match in one CPU's bank has no effect on any other CPU's flag or interrupt output.
- R12: Writes to the counter offsets are ignored, and reads of an undefined offset (0x1C, or any address with bits above bit 4 set) return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the counter, divider and all banks |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Register access strobe for this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_cpu | input | CPU_W | Index of the CPU making the access; selects the bank |
| acc_addr | input | ADDR_W | Byte offset inside the register window |
| acc_wdata | input | DATA_W | Write data |
| acc_rdata | output | DATA_W | Read data, valid in the same cycle as the read access |
| irq_o | output | NUM_CPU | Per-CPU level interrupt, one bit per bank |

## Verification
The assertions take for granted that no status clear from a CPU lands in the same clock as a match in that CPU's bank, because the two are defined with match taking priority. They also assume that the counter never wraps during a run. The stimulus keeps within this: it works out the exact clock of every match from the divider and the compare distance, and it places each status clear several clocks away from any match. It also keeps all counter values far below 2^32. Before each change to the divider, the bench clears run, so every timing check starts from a known divider phase.

// File: rtl/sct_pkg.sv
package sct_pkg;
   // word index = byte offset [4:2]
   localparam logic [2:0] W_CNT_LO = 3'd0;
   localparam logic [2:0] W_CNT_HI = 3'd1;
   localparam logic [2:0] W_CTRL   = 3'd2;
   localparam logic [2:0] W_STAT   = 3'd3;
   localparam logic [2:0] W_CMP_LO = 3'd4;
   localparam logic [2:0] W_CMP_HI = 3'd5;
   localparam logic [2:0] W_STEP   = 3'd6;

   // control bit positions
   localparam int B_RUN   = 0;
   localparam int B_CMPEN = 1;
   localparam int B_IRQEN = 2;
   localparam int B_AUTO  = 3;
   localparam int B_DIV   = 8;
   localparam int DIV_MAX_W = 8;

   typedef struct packed {
      logic auto_en;
      logic irq_en;
      logic cmp_en;
   } bank_ctl_t;
endpackage

// File: rtl/sct_count.sv
module sct_count #(
   parameter int CNT_W   = 64,
   parameter int PRESC_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic [PRESC_W-1:0] presc,
   output logic [CNT_W-1:0]   cnt,
   output logic               fresh
);
   logic [PRESC_W-1:0] div_q;
   logic               step;

   assign step = run && (div_q == presc);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_q <= '0;
         cnt   <= '0;
         fresh <= 1'b0;
      end else begin
         fresh <= step;
         if (!run || step) div_q <= '0;
         else              div_q <= div_q + 1'b1;
         if (step) cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/sct_bank.sv
module sct_bank
   import sct_pkg::*;
#(
   parameter int CNT_W  = 64,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              fresh,
   input  logic              wr_ctl,
   input  logic              wr_stat,
   input  logic              wr_clo,
   input  logic              wr_chi,
   input  logic              wr_step,
   input  logic [DATA_W-1:0] wdata,
   output logic [CNT_W-1:0]  cmp_o,
   output logic [DATA_W-1:0] step_o,
   output bank_ctl_t         ctl_o,
   output logic              flag_o,
   output logic              irq_o,
   output logic              hit_o,
   output logic              clr_o
);
   localparam int HI_W = CNT_W - DATA_W;

   logic [CNT_W-1:0]  cmp_q;
   logic [DATA_W-1:0] step_q;
   bank_ctl_t         ctl_q;
   logic              flag_q, irq_q;
   logic              hit, clr;

   assign hit = run && ctl_q.cmp_en && fresh && (cnt == cmp_q);
   assign clr = wr_stat && wdata[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmp_q  <= '0;
         step_q <= '0;
         ctl_q  <= '0;
      end else begin
         if (wr_ctl) begin
            ctl_q.cmp_en  <= wdata[B_CMPEN];
            ctl_q.irq_en  <= wdata[B_IRQEN];
            ctl_q.auto_en <= wdata[B_AUTO];
         end
         if (wr_step) step_q <= wdata;
         // software writes take priority over the automatic advance
         if (wr_clo)
            cmp_q[DATA_W-1:0] <= wdata;
         else if (wr_chi)
            cmp_q[CNT_W-1:DATA_W] <= wdata[HI_W-1:0];
         else if (hit && ctl_q.auto_en)
            cmp_q <= cmp_q + CNT_W'(step_q);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         irq_q  <= 1'b0;
      end else if (hit) begin
         flag_q <= 1'b1;
         if (!flag_q && ctl_q.irq_en) irq_q <= 1'b1;
      end else if (clr) begin
         flag_q <= 1'b0;
         irq_q  <= 1'b0;
      end
   end

   assign cmp_o  = cmp_q;
   assign step_o = step_q;
   assign ctl_o  = ctl_q;
   assign flag_o = flag_q;
   assign irq_o  = irq_q;
   assign hit_o  = hit;
   assign clr_o  = clr;
endmodule

// File: rtl/sct_timer.sv
module sct_timer
   import sct_pkg::*;
#(
   parameter int NUM_CPU  = 4,
   parameter int CNT_W    = 64,
   parameter int DATA_W   = 32,
   parameter int PRESC_W  = 8,
   parameter int ADDR_W   = 8,
   localparam int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               acc_en,
   input  logic               acc_wr,
   input  logic [CPU_W-1:0]   acc_cpu,
   input  logic [ADDR_W-1:0]  acc_addr,
   input  logic [DATA_W-1:0]  acc_wdata,
   output logic [DATA_W-1:0]  acc_rdata,
   output logic [NUM_CPU-1:0] irq_o
);
   localparam int HI_W = CNT_W - DATA_W;

   if (NUM_CPU < 1 || NUM_CPU > 4) begin : g_bad_cpu
      $error("sct_timer: NUM_CPU must lie in 1..4");
   end
   if (DATA_W != 32 || CNT_W != 2 * DATA_W) begin : g_bad_width
      $error("sct_timer: counter must be two 32-bit words");
   end
   if (PRESC_W < 1 || PRESC_W > DIV_MAX_W) begin : g_bad_presc
      $error("sct_timer: divider field is at most 8 bits");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("sct_timer: address must cover the 0x00..0x1C window");
   end

   // access decode
   logic       in_win, cpu_ok, wr_ok;
   logic [2:0] word;

   assign in_win = ((acc_addr >> 5) == '0);
   assign cpu_ok = (32'(acc_cpu) < NUM_CPU);
   assign word   = acc_addr[4:2];
   assign wr_ok  = acc_en && acc_wr && in_win && cpu_ok;

   // shared control bits
   logic               run_q;
   logic [PRESC_W-1:0] presc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         presc_q <= '0;
      end else if (wr_ok && word == W_CTRL) begin
         run_q   <= acc_wdata[B_RUN];
         presc_q <= acc_wdata[B_DIV +: PRESC_W];
      end
   end

   logic [CNT_W-1:0] cnt;
   logic             fresh;

   sct_count #(.CNT_W(CNT_W), .PRESC_W(PRESC_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run_q),
      .presc (presc_q),
      .cnt   (cnt),
      .fresh (fresh)
   );

   // banks
   logic [CNT_W-1:0]   cmp_a  [NUM_CPU];
   logic [DATA_W-1:0]  step_a [NUM_CPU];
   bank_ctl_t          ctl_a  [NUM_CPU];
   logic [NUM_CPU-1:0] flag_v, hit_v, clr_v;

   for (genvar i = 0; i < NUM_CPU; i++) begin : g_bank
      logic mine;
      assign mine = wr_ok && (acc_cpu == CPU_W'(i));

      sct_bank #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .run     (run_q),
         .cnt     (cnt),
         .fresh   (fresh),
         .wr_ctl  (mine && word == W_CTRL),
         .wr_stat (mine && word == W_STAT),
         .wr_clo  (mine && word == W_CMP_LO),
         .wr_chi  (mine && word == W_CMP_HI),
         .wr_step (mine && word == W_STEP),
         .wdata   (acc_wdata),
         .cmp_o   (cmp_a[i]),
         .step_o  (step_a[i]),
         .ctl_o   (ctl_a[i]),
         .flag_o  (flag_v[i]),
         .irq_o   (irq_o[i]),
         .hit_o   (hit_v[i]),
         .clr_o   (clr_v[i])
      );
   end

   // read mux
   always_comb begin
      acc_rdata = '0;
      if (acc_en && !acc_wr && in_win && cpu_ok) begin
         case (word)
            W_CNT_LO: acc_rdata = cnt[DATA_W-1:0];
            W_CNT_HI: acc_rdata = DATA_W'(cnt[CNT_W-1:DATA_W]);
            W_CTRL: begin
               acc_rdata[B_RUN]              = run_q;
               acc_rdata[B_DIV +: PRESC_W]   = presc_q;
               acc_rdata[B_CMPEN]            = ctl_a[acc_cpu].cmp_en;
               acc_rdata[B_IRQEN]            = ctl_a[acc_cpu].irq_en;
               acc_rdata[B_AUTO]             = ctl_a[acc_cpu].auto_en;
            end
            W_STAT:   acc_rdata[0] = flag_v[acc_cpu];
            W_CMP_LO: acc_rdata = cmp_a[acc_cpu][DATA_W-1:0];
            W_CMP_HI: acc_rdata = DATA_W'(cmp_a[acc_cpu][CNT_W-1:DATA_W]);
            W_STEP:   acc_rdata = step_a[acc_cpu];
            default:  acc_rdata = '0;
         endcase
      end
   end

   logic [HI_W-1:0] unused_hi;
   assign unused_hi = '0;
endmodule

// File: rtl/sct_checker.sv
module sct_checker #(
   parameter int NUM_CPU = 4,
   parameter int CNT_W   = 64
) (
   input logic               clk,
   input logic               rst_n,
   input logic               run,
   input logic [CNT_W-1:0]   cnt,
   input logic [NUM_CPU-1:0] flag,
   input logic [NUM_CPU-1:0] irq,
   input logic [NUM_CPU-1:0] hit,
   input logic [NUM_CPU-1:0] clr
);
   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(cnt)); // R4
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1)); // R4

   for (genvar i = 0; i < NUM_CPU; i++) begin : g_cpu
      AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
         hit[i] |=> flag[i]); // R5
      AST_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
         irq[i] |-> flag[i]); // R6
      AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(irq[i]) |-> $rose(flag[i])); // R6
      AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
         (clr[i] && !hit[i]) |=> (!flag[i] && !irq[i])); // R8
   end
endmodule

bind sct_timer sct_checker #(.NUM_CPU(NUM_CPU), .CNT_W(CNT_W)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .run   (run_q),
   .cnt   (cnt),
   .flag  (flag_v),
   .irq   (irq_o),
   .hit   (hit_v),
   .clr   (clr_v)
);

// File: tb/sim_sct_timer.sv
`timescale 1ns/1ps
module sim_sct_timer;
   localparam int NC = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_en = 1'b0, acc_wr = 1'b0;
   logic [1:0]  acc_cpu = '0;
   logic [7:0]  acc_addr = '0;
   logic [31:0] acc_wdata = '0;
   logic [31:0] acc_rdata;
   logic [NC-1:0] irq_o;

   int checks = 0, failures = 0;
   logic done = 1'b0;

   always #2.5 clk = ~clk;

   sct_timer #(.NUM_CPU(NC)) u0 (
      .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
      .acc_cpu(acc_cpu), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
      .acc_rdata(acc_rdata), .irq_o(irq_o)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got=0x%08h exp=0x%08h", tag, got, exp);
      end
   endtask

   // called at a negedge; returns at the negedge after the write edge
   task automatic wr(input int cpu, input logic [7:0] a, input logic [31:0] d);
      acc_en = 1'b1; acc_wr = 1'b1; acc_cpu = 2'(cpu); acc_addr = a; acc_wdata = d;
      @(posedge clk);
      @(negedge clk);
      acc_en = 1'b0; acc_wr = 1'b0;
   endtask

   task automatic rd(input int cpu, input logic [7:0] a, output logic [31:0] d);
      acc_en = 1'b1; acc_wr = 1'b0; acc_cpu = 2'(cpu); acc_addr = a;
      #1 d = acc_rdata;
      acc_en = 1'b0;
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] v, c0, c1;
      edges(3);
      rst_n = 1'b1;
      @(negedge clk);

      // R10: reset values in every bank
      for (int c = 0; c < NC; c++)
         for (int w = 0; w < 7; w++) begin
            rd(c, 8'(w * 4), v);
            chk($sformatf("R10 cpu%0d off%0h", c, w * 4), v, 32'h0);
         end
      chk("R10 irq", 32'(irq_o), 32'h0);

      // R12: counter writes ignored, undefined offsets read zero
      wr(0, 8'h00, 32'h55);
      wr(0, 8'h04, 32'h66);
      rd(0, 8'h00, v); chk("R12 cnt lo write ignored", v, 32'h0);
      rd(0, 8'h04, v); chk("R12 cnt hi write ignored", v, 32'h0);
      wr(1, 8'h18, 32'h1234);
      rd(1, 8'h1C, v); chk("R12 undefined 0x1C", v, 32'h0);
      rd(1, 8'h38, v); chk("R12 alias above window", v, 32'h0);
      rd(1, 8'h1B, v); chk("R1 step via unaligned addr", v, 32'h1234);
      wr(1, 8'h18, 32'h0);

      // R4: divider sweep
      for (int p = 0; p < 4; p++) begin
         rd(0, 8'h00, c0);
         wr(0, 8'h08, 32'(p << 8) | 32'h1);
         for (int n = 1; n <= 9; n++) begin
            edges(1);
            rd(0, 8'h00, v);
            chk($sformatf("R4 div%0d n%0d", p, n), v, c0 + 32'(n / (p + 1)));
         end
         wr(0, 8'h08, 32'h0);
         rd(0, 8'h00, c0);
         edges(8);
         rd(0, 8'h00, v);
         chk($sformatf("R4 hold div%0d", p), v, c0);
      end

      // R2 / R3: shared versus banked control bits
      wr(1, 8'h08, 32'h0000_030E);
      rd(0, 8'h08, v); chk("R2 cpu0 sees shared only", v, 32'h0000_0300);
      rd(1, 8'h08, v); chk("R3 cpu1 merged", v, 32'h0000_030E);
      wr(2, 8'h08, 32'hFFFF_FFF1);
      rd(2, 8'h08, v); chk("R3 cpu2 masked", v, 32'h0000_FF01);
      rd(1, 8'h08, v); chk("R2 cpu1 banked kept", v, 32'h0000_FF0F);
      wr(2, 8'h08, 32'h0);
      wr(1, 8'h08, 32'h0);
      rd(1, 8'h08, v); chk("R2 cpu1 cleared", v, 32'h0);

      // R9: compare halves independent, banked
      wr(3, 8'h10, 32'hAAAA_5555);
      wr(3, 8'h14, 32'h1234_5678);
      wr(3, 8'h10, 32'h0000_0001);
      rd(3, 8'h14, v); chk("R9 hi kept", v, 32'h1234_5678);
      rd(3, 8'h10, v); chk("R9 lo new", v, 32'h0000_0001);
      wr(3, 8'h14, 32'h9);
      rd(3, 8'h10, v); chk("R9 lo kept", v, 32'h0000_0001);
      rd(0, 8'h14, v); chk("R9 cpu0 untouched", v, 32'h0);
      wr(3, 8'h10, 32'h0);
      wr(3, 8'h14, 32'h0);

      // R5 / R6 / R11: single match on cpu0, divider 1, distance 5
      rd(0, 8'h00, c0);
      wr(0, 8'h10, c0 + 32'd5);
      wr(0, 8'h08, 32'h0000_0107);
      edges(10);
      rd(0, 8'h0C, v); chk("R5 flag not yet", v, 32'h0);
      chk("R6 irq not yet", 32'(irq_o), 32'h0);
      edges(1);
      rd(0, 8'h0C, v); chk("R5 flag set", v, 32'h1);
      chk("R11 only cpu0 irq", 32'(irq_o), 32'h1);
      for (int c = 1; c < NC; c++) begin
         rd(c, 8'h0C, v); chk($sformatf("R11 cpu%0d flag", c), v, 32'h0);
      end
      edges(6);
      chk("R6 irq held", 32'(irq_o), 32'h1);
      // R8: write 0 no effect, write 1 clears
      wr(0, 8'h0C, 32'hFFFF_FFFE);
      rd(0, 8'h0C, v); chk("R8 write0 no effect", v, 32'h1);
      chk("R8 irq kept", 32'(irq_o), 32'h1);
      wr(0, 8'h0C, 32'h1);
      rd(0, 8'h0C, v); chk("R8 flag cleared", v, 32'h0);
      chk("R8 irq cleared", 32'(irq_o), 32'h0);
      wr(0, 8'h08, 32'h0);

      // R7 / R6: auto-increment on cpu2, divider 0, step 6
      rd(0, 8'h00, c0);
      wr(2, 8'h10, c0 + 32'd4);
      wr(2, 8'h18, 32'd6);
      wr(2, 8'h08, 32'h0000_000B);          // T0: run, compare, auto
      edges(5);                              // T0+5
      rd(2, 8'h0C, v); chk("R5 cpu2 flag", v, 32'h1);
      chk("R6 no irq while disabled", 32'(irq_o), 32'h0);
      rd(2, 8'h10, v); chk("R7 first advance", v, c0 + 32'd10);
      wr(2, 8'h08, 32'h0000_000F);          // T0+6: enable irq, flag already set
      edges(6);                              // T0+12
      rd(2, 8'h10, v); chk("R7 second advance", v, c0 + 32'd16);
      chk("R6 no rise while flag set", 32'(irq_o), 32'h0);
      wr(2, 8'h0C, 32'h1);                   // T0+13
      edges(3);                              // T0+16
      rd(2, 8'h0C, v); chk("R8 cpu2 clear", v, 32'h0);
      edges(1);                              // T0+17
      rd(2, 8'h0C, v); chk("R7 third match flag", v, 32'h1);
      chk("R6 irq on fresh rise", 32'(irq_o), 32'h4);
      rd(2, 8'h10, v); chk("R7 third advance", v, c0 + 32'd22);
      rd(2, 8'h14, c1); chk("R7 hi unchanged", c1, 32'h0);
      wr(2, 8'h08, 32'h0);
      wr(2, 8'h0C, 32'h1);
      chk("R8 final irq clear", 32'(irq_o), 32'h0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule